// File: doc/BRIEF.md
# Four-Channel Wiper Command Decoder on a Two-Wire Serial Bus

This block sits behind a two-wire serial bus as a 7-bit slave. It watches SCL and SDA with its own system clock, finds START and STOP conditions, matches the device address and acknowledges it. It then decodes the bytes that follow into commands for a bank of four 8-bit wiper settings. A write carries an instruction byte and then any number of data bytes. The instruction byte selects a channel, can reset that channel to midscale, can set or clear shutdown for that channel alone, and sets two general-purpose logic outputs. Each data byte that follows produces a one-cycle write strobe with the channel and the code.

The block keeps a copy of the four wiper codes so that a read can return them. A read returns the code of the channel chosen by the most recent instruction byte. It returns that byte again for as long as the master keeps acknowledging. The block drives SDA only through an open-drain pull-down output. It does not stretch the clock.

Top module: `wiper_cmd_i2c`

## Requirements
- R1: The address byte is matched against 0,1,0,1,1 followed by `devAddrPins[1]` and `devAddrPins[0]`, with the R/W bit last (0 = write, 1 = read). On a match the block pulls SDA low during the ninth clock. On a mismatch it does not acknowledge that byte or any later byte, and it issues no command until the next START.
- R2: Fields of the instruction byte: bits 6:5 select the channel, bit 4 is midscale reset, bit 3 is shutdown, bit 2 drives `gpOut[1]` and bit 1 drives `gpOut[0]`. Bits 7 and 0 have no effect.
- R3: In a write, every byte after the address is acknowledged. Each data byte after the instruction byte gives one single-cycle `wrStrobe` pulse, with `wrChan` set to the selected channel and `wrCode` set to the byte.
- R4: When the reset bit is 1, the selected channel's stored code becomes 0x80. `chanReset` pulses for that channel only, for one cycle.
- R5: The shutdown bit sets (1) or clears (0) `shutdownOn` for the selected channel only. The other channels keep their state.
- R6: A write that ends after the instruction byte updates `gpOut`, the selection, reset and shutdown, and gives no `wrStrobe`.
- R7: In a read, the stored code of the selected channel is sent MSB first. It starts right after the address acknowledge, and the same byte is sent again after each master acknowledge.
- R8: When the master does not acknowledge a read byte, the block releases SDA and stays quiet until a STOP or START.
- R9: After reset: `gpOut` is 0, `shutdownOn` is 0, SDA is released, every stored code is 0x80 and channel 0 is selected.
- R10: A START at any point (repeated START included) restarts address reception. A STOP returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rstN | input | 1 | Active-low reset |
| sclIn | input | 1 | Serial clock level from the bus |
| sdaIn | input | 1 | Serial data level from the bus |
| devAddrPins | input | 2 | Low two bits of the device address |
| sdaPullLow | output | 1 | 1 pulls SDA low (open-drain drive) |
| wrStrobe | output | 1 | One-cycle pulse for each data byte written |
| wrChan | output | 2 | Channel of the write |
| wrCode | output | 8 | Code of the write |
| chanReset | output | 4 | One-cycle midscale reset pulse per channel |
| shutdownOn | output | 4 | Shutdown state per channel |
| gpOut | output | 2 | General-purpose logic outputs |

## Verification
The assertions assume a master that changes SDA only while SCL is low, except to form START and STOP. They also assume that every SCL phase lasts several system clocks longer than the input synchronizer, so that edges arrive in order and data bytes never come closer together than two cycles. The bench's master holds each quarter bit for ten clocks and never drives SDA against the slave: it releases the line for the acknowledge slot and for read bits. Every byte sequence therefore stays within those assumptions, and the assertions on single-cycle strobes and on SDA changing only after a clock edge remain valid.

// File: rtl/wiper_i2c_pkg.sv
package wiper_i2c_pkg;
  localparam int CODE_W   = 8;
  localparam int N_CHAN   = 4;
  localparam int CHAN_W   = $clog2(N_CHAN);
  localparam int GP_W     = 2;
  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);
  localparam logic [4:0] ADDR_FIXED = 5'b01011;

  // instruction byte field positions
  localparam int F_CHAN_LO = 5;
  localparam int F_RST     = 4;
  localparam int F_SD      = 3;
  localparam int F_GP_LO   = 1;

  typedef struct packed {
    logic              instrValid;
    logic              dataValid;
    logic [CODE_W-1:0] byteVal;
  } cmd_t;
endpackage

// File: rtl/wiper_i2c_sync.sv
module wiper_i2c_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) pipe <= '1;
        else       pipe <= din;
    end else begin : g_many
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) pipe <= '1;
        else       pipe <= {pipe[STAGES-2:0], din};
    end
  endgenerate

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/wiper_i2c_ctrl.sv
module wiper_i2c_ctrl
  import wiper_i2c_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclS,
  input  logic              sdaS,
  input  logic [1:0]        addrPins,
  input  logic [CODE_W-1:0] readCode,
  output cmd_t              cmd,
  output logic              sdaPull
);
  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_INSTR, S_DATA, S_READ} state_t;

  state_t            state;
  logic              sclQ, sdaQ;
  logic [3:0]        bitCnt;
  logic [CODE_W-1:0] shiftIn, shiftOut;
  logic              isRead, masterNack;
  logic              sclRise, sclFall, startSeen, stopSeen;

  assign sclRise   = sclS & ~sclQ;
  assign sclFall   = ~sclS & sclQ;
  assign startSeen = sclS & sclQ & sdaQ & ~sdaS;
  assign stopSeen  = sclS & sclQ & ~sdaQ & sdaS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= S_IDLE;
      sclQ       <= 1'b1;
      sdaQ       <= 1'b1;
      bitCnt     <= '0;
      shiftIn    <= '0;
      shiftOut   <= '0;
      isRead     <= 1'b0;
      masterNack <= 1'b0;
      sdaPull    <= 1'b0;
      cmd        <= '0;
    end else begin
      cmd  <= '0;
      sclQ <= sclS;
      sdaQ <= sdaS;
      if (startSeen) begin
        state   <= S_ADDR;
        bitCnt  <= '0;
        sdaPull <= 1'b0;
      end else if (stopSeen) begin
        state   <= S_IDLE;
        bitCnt  <= '0;
        sdaPull <= 1'b0;
      end else if (state != S_IDLE) begin
        if (sclRise) begin
          if (bitCnt < 4'd8) shiftIn <= {shiftIn[CODE_W-2:0], sdaS};
          if (bitCnt == 4'd8) masterNack <= sdaS;
          bitCnt <= bitCnt + 4'd1;
        end else if (sclFall) begin
          if (bitCnt == 4'd8) begin
            case (state)
              S_ADDR: begin
                if (shiftIn[7:1] == {ADDR_FIXED, addrPins}) begin
                  sdaPull <= 1'b1;
                  isRead  <= shiftIn[0];
                end else begin
                  state <= S_IDLE;
                end
              end
              S_INSTR: begin
                sdaPull        <= 1'b1;
                cmd.instrValid <= 1'b1;
                cmd.byteVal    <= shiftIn;
              end
              S_DATA: begin
                sdaPull       <= 1'b1;
                cmd.dataValid <= 1'b1;
                cmd.byteVal   <= shiftIn;
              end
              default: sdaPull <= 1'b0;
            endcase
          end else if (bitCnt == 4'd9) begin
            bitCnt <= '0;
            case (state)
              S_ADDR: begin
                if (isRead) begin
                  state    <= S_READ;
                  shiftOut <= readCode;
                  sdaPull  <= ~readCode[CODE_W-1];
                end else begin
                  state   <= S_INSTR;
                  sdaPull <= 1'b0;
                end
              end
              S_READ: begin
                if (masterNack) begin
                  state   <= S_IDLE;
                  sdaPull <= 1'b0;
                end else begin
                  shiftOut <= readCode;
                  sdaPull  <= ~readCode[CODE_W-1];
                end
              end
              default: begin
                state   <= S_DATA;
                sdaPull <= 1'b0;
              end
            endcase
          end else if (state == S_READ && bitCnt != 4'd0) begin
            shiftOut <= {shiftOut[CODE_W-2:0], 1'b0};
            sdaPull  <= ~shiftOut[CODE_W-2];
          end
        end
      end
    end
  end

  // R1: idle slave never holds the line
  p_idle_released_r1: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE) |-> !sdaPull);

  // R10: SDA drive changes only after an SCL fall or a START/STOP
  p_sda_moves_on_edge_r10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaPull) |-> $past(sclFall || startSeen || stopSeen));

  // R3: an acknowledge starts only after eight received bits
  p_ack_after_eight_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(sdaPull) && state != S_READ) |-> (bitCnt == 4'd8));

  // R3: command pulses never overlap
  p_cmd_exclusive_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(cmd.instrValid && cmd.dataValid));
endmodule

// File: rtl/wiper_i2c_dp.sv
module wiper_i2c_dp
  import wiper_i2c_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  cmd_t              cmd,
  output logic              wrStrobe,
  output logic [CHAN_W-1:0] wrChan,
  output logic [CODE_W-1:0] wrCode,
  output logic [N_CHAN-1:0] chanReset,
  output logic [N_CHAN-1:0] shutdownOn,
  output logic [GP_W-1:0]   gpOut,
  output logic [CODE_W-1:0] readCode
);
  logic [CHAN_W-1:0] selReg, selNew;
  logic [CODE_W-1:0] codes [N_CHAN];

  assign selNew = cmd.byteVal[F_CHAN_LO +: CHAN_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selReg   <= '0;
      gpOut    <= '0;
      wrStrobe <= 1'b0;
      wrChan   <= '0;
      wrCode   <= '0;
    end else begin
      wrStrobe <= cmd.dataValid;
      if (cmd.instrValid) begin
        selReg <= selNew;
        gpOut  <= cmd.byteVal[F_GP_LO +: GP_W];
      end
      if (cmd.dataValid) begin
        wrChan <= selReg;
        wrCode <= cmd.byteVal;
      end
    end
  end

  generate
    for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
      logic hitInstr, hitData;
      assign hitInstr = cmd.instrValid && (selNew == CHAN_W'(c));
      assign hitData  = cmd.dataValid && (selReg == CHAN_W'(c));

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          codes[c]      <= MID_CODE;
          shutdownOn[c] <= 1'b0;
          chanReset[c]  <= 1'b0;
        end else begin
          chanReset[c] <= hitInstr && cmd.byteVal[F_RST];
          if (hitInstr) begin
            shutdownOn[c] <= cmd.byteVal[F_SD];
            if (cmd.byteVal[F_RST]) codes[c] <= MID_CODE;
          end
          if (hitData) codes[c] <= cmd.byteVal;
        end
      end
    end
  endgenerate

  assign readCode = codes[selReg];

  // R3: write strobe is a single-cycle pulse
  p_strobe_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> !wrStrobe);

  // R4: at most one channel reset at a time
  p_reset_onehot_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(chanReset));

  // R4: the reset channel holds midscale and is the selected one
  p_reset_midscale_r4: assert property (@(posedge clk) disable iff (!rstN)
    (|chanReset) |-> (readCode == MID_CODE));

  // R5: one instruction changes at most one shutdown bit
  p_sd_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    $countones(shutdownOn ^ $past(shutdownOn)) <= 1);
endmodule

// File: rtl/wiper_cmd_i2c.sv
module wiper_cmd_i2c
  import wiper_i2c_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  input  logic [1:0]  devAddrPins,
  output logic        sdaPullLow,
  output logic        wrStrobe,
  output logic [1:0]  wrChan,
  output logic [7:0]  wrCode,
  output logic [3:0]  chanReset,
  output logic [3:0]  shutdownOn,
  output logic [1:0]  gpOut
);
  logic              sclS, sdaS;
  cmd_t              cmd;
  logic [CODE_W-1:0] readCode;

  wiper_i2c_sync #(.STAGES(SYNC_STAGES)) u_sclSync (
    .clk(clk), .rstN(rstN), .din(sclIn), .dout(sclS));
  wiper_i2c_sync #(.STAGES(SYNC_STAGES)) u_sdaSync (
    .clk(clk), .rstN(rstN), .din(sdaIn), .dout(sdaS));

  wiper_i2c_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sclS(sclS), .sdaS(sdaS),
    .addrPins(devAddrPins), .readCode(readCode),
    .cmd(cmd), .sdaPull(sdaPullLow));

  wiper_i2c_dp u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .wrStrobe(wrStrobe), .wrChan(wrChan), .wrCode(wrCode),
    .chanReset(chanReset), .shutdownOn(shutdownOn),
    .gpOut(gpOut), .readCode(readCode));
endmodule

// File: tb/sim_wiper_cmd_i2c.sv
`timescale 1ns/1ps
module sim_wiper_cmd_i2c;
  localparam int Q = 10;            // clocks per quarter bit
  localparam logic [1:0] PINS = 2'b10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclDrv = 1'b1, sdaDrv = 1'b1;
  logic sdaPullLow, wrStrobe;
  logic [1:0] wrChan, gpOut;
  logic [7:0] wrCode;
  logic [3:0] chanReset, shutdownOn;
  logic busSda;

  always #2.5 clk = ~clk;
  assign busSda = sdaDrv & ~sdaPullLow;

  wiper_cmd_i2c u0 (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(busSda),
    .devAddrPins(PINS), .sdaPullLow(sdaPullLow), .wrStrobe(wrStrobe),
    .wrChan(wrChan), .wrCode(wrCode), .chanReset(chanReset),
    .shutdownOn(shutdownOn), .gpOut(gpOut));

  int checks = 0, failures = 0;
  bit finished = 0;
  bit cmpOn = 0;

  // reference model state
  logic [7:0] expCode [4];
  logic [3:0] expSd;
  logic [1:0] expGp;
  int         expSel;
  logic [9:0] expWrQ[$], gotWrQ[$];
  int         expRstQ[$], gotRstQ[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rstN && wrStrobe) gotWrQ.push_back({wrChan, wrCode});
    if (rstN) for (int k = 0; k < 4; k++) if (chanReset[k]) gotRstQ.push_back(k);
  end

  // per-clock comparison of held outputs against the model (R5 R6 R9)
  always @(negedge clk) begin
    if (cmpOn && !finished) begin
      checks++;
      if (gpOut !== expGp || shutdownOn !== expSd) begin
        failures++;
        $display("FAIL R5 R6 R9 outputs actual gp=%b sd=%b expected gp=%b sd=%b",
                 gpOut, shutdownOn, expGp, expSd);
      end
    end
  end

  task automatic waitClk(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic idleGap(input int n);
    cmpOn = 1; waitClk(n); cmpOn = 0;
  endtask

  task automatic startCond();
    sdaDrv = 1; waitClk(Q); sclDrv = 1; waitClk(Q);
    sdaDrv = 0; waitClk(Q); sclDrv = 0; waitClk(Q);
  endtask

  task automatic stopCond();
    sdaDrv = 0; waitClk(Q); sclDrv = 1; waitClk(Q); sdaDrv = 1; waitClk(Q);
  endtask

  task automatic writeBit(input logic b);
    sdaDrv = b; waitClk(Q); sclDrv = 1; waitClk(2*Q); sclDrv = 0; waitClk(Q);
  endtask

  task automatic readBit(output logic b);
    sdaDrv = 1; waitClk(Q); sclDrv = 1; waitClk(Q);
    b = busSda; waitClk(Q); sclDrv = 0; waitClk(Q);
  endtask

  task automatic sendByte(input logic [7:0] v, output bit acked);
    logic b;
    for (int i = 7; i >= 0; i--) writeBit(v[i]);
    readBit(b);
    acked = !b;
  endtask

  task automatic recvByte(output logic [7:0] v, input bit giveAck);
    logic b;
    for (int i = 7; i >= 0; i--) begin readBit(b); v[i] = b; end
    writeBit(!giveAck);
  endtask

  task automatic compareQueues(input string req);
    check(gotWrQ.size() == expWrQ.size(), req, gotWrQ.size(), expWrQ.size());
    while (gotWrQ.size() > 0 && expWrQ.size() > 0) begin
      logic [9:0] g, e;
      g = gotWrQ.pop_front(); e = expWrQ.pop_front();
      check(g == e, req, g, e);
    end
    check(gotRstQ.size() == expRstQ.size(), "R4 reset pulse count", gotRstQ.size(), expRstQ.size());
    while (gotRstQ.size() > 0 && expRstQ.size() > 0) begin
      int g, e;
      g = gotRstQ.pop_front(); e = expRstQ.pop_front();
      check(g == e, "R4 reset channel", g, e);
    end
    gotWrQ.delete(); expWrQ.delete(); gotRstQ.delete(); expRstQ.delete();
  endtask

  task automatic doWrite(input logic [1:0] pins, input logic [7:0] instr, input int n,
                         input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2,
                         input bit match, input bit noStop);
    logic [7:0] d [3];
    bit ack;
    d[0] = d0; d[1] = d1; d[2] = d2;
    startCond();
    sendByte({5'b01011, pins, 1'b0}, ack);
    check(ack == match, "R1 address acknowledge", ack, match);
    sendByte(instr, ack);
    check(ack == match, "R1 R3 instruction acknowledge", ack, match);
    if (match) begin
      expSel = int'(instr[6:5]);
      if (instr[4]) begin expCode[expSel] = 8'h80; expRstQ.push_back(expSel); end
      expSd[expSel] = instr[3];
      expGp = {instr[2], instr[1]};
    end
    for (int i = 0; i < n; i++) begin
      sendByte(d[i], ack);
      check(ack == match, "R1 R3 data acknowledge", ack, match);
      if (match) begin
        expCode[expSel] = d[i];
        expWrQ.push_back({2'(expSel), d[i]});
      end
    end
    if (!noStop) stopCond();
    idleGap(20);
    compareQueues("R3 R6 write strobes");
  endtask

  task automatic doRead(input int n, input bit lastAck, input string req);
    bit ack;
    logic [7:0] v;
    startCond();
    sendByte({5'b01011, PINS, 1'b1}, ack);
    check(ack, "R1 read address acknowledge", ack, 1);
    for (int i = 0; i < n; i++) begin
      recvByte(v, (i < n-1) || lastAck);
      check(v == expCode[expSel], req, v, expCode[expSel]);
    end
  endtask

  initial begin
    for (int k = 0; k < 4; k++) expCode[k] = 8'h80;
    expSd = '0; expGp = '0; expSel = 0;
    waitClk(10);
    rstN = 1;
    waitClk(5);

    // R9 reset state
    check(sdaPullLow == 1'b0, "R9 SDA released after reset", sdaPullLow, 0);
    idleGap(20);

    // R9 R7: read before any write returns midscale of channel 0
    doRead(1, 1'b0, "R9 R7 read after reset");
    stopCond(); idleGap(20);

    // R2 R3: channel 2, gpOut[1] set, one data byte
    doWrite(PINS, 8'h44, 1, 8'h3C, 8'h00, 8'h00, 1'b1, 1'b0);

    // R3: channel 1, three data bytes
    doWrite(PINS, 8'h20, 3, 8'h11, 8'h22, 8'h33, 1'b1, 1'b0);

    // R6 R5: instruction only on channel 3, shutdown and gpOut[0]
    doWrite(PINS, 8'h6A, 0, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0);

    // R1: wrong address pins, nothing acknowledged or applied
    doWrite(2'b01, 8'h44, 1, 8'h77, 8'h00, 8'h00, 1'b0, 1'b0);

    // R7 R8: select channel 1, read three bytes, last one not acknowledged
    doWrite(PINS, 8'h20, 0, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0);
    doRead(3, 1'b0, "R7 repeated read of channel 1");
    waitClk(5);
    check(sdaPullLow == 1'b0, "R8 SDA released after master NACK", sdaPullLow, 0);
    waitClk(2*Q);
    check(sdaPullLow == 1'b0, "R8 SDA still released", sdaPullLow, 0);
    stopCond(); idleGap(20);

    // R4 R2: reset channel 2 with both ignored bits set
    doWrite(PINS, 8'hD1, 0, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0);
    doRead(1, 1'b0, "R4 midscale after reset command");
    stopCond(); idleGap(20);

    // R5: shutdown channel 0, then clear channel 3 only
    doWrite(PINS, 8'h08, 0, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0);
    check(shutdownOn == 4'b1001, "R5 shutdown set on channel 0", shutdownOn, 4'b1001);
    doWrite(PINS, 8'h60, 0, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0);
    check(shutdownOn == 4'b0001, "R5 shutdown cleared on channel 3", shutdownOn, 4'b0001);

    // R10: write then repeated START into a read
    doWrite(PINS, 8'h08, 1, 8'h5A, 8'h00, 8'h00, 1'b1, 1'b1);
    doRead(1, 1'b0, "R10 read after repeated START");
    stopCond(); idleGap(20);

    // R8 R10: bus usable after the NACK sequence
    doWrite(PINS, 8'h00, 1, 8'hA5, 8'h00, 8'h00, 1'b1, 1'b0);
    doRead(2, 1'b0, "R8 R10 read after recovery");
    stopCond(); idleGap(20);

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    waitClk(150000);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule